// File: doc/BRIEF.md
# Two-Channel Hardware Breakpoint Comparator

This block watches the processor's bus and decides when a debug break must be taken. It has two channels, A and B. Each channel holds a break address with a per-bit don't-care mask, an address-space identifier (ASID) with an ignore control, and two qualifier fields. One field picks which kind of access counts: instruction fetch, operand access, or both. The other picks which direction counts: read, write, or both. Channel B can also require the operand data to equal a stored value. That data test uses its own don't-care mask and looks only at the byte lanes the access carries.

The channels can fire independently. They can also be chained, so that a channel A match only arms the block and a later channel B match produces the break. A qualified match sets a sticky per-channel flag and pulses a break request, unless the CPU's block bit is set. Alongside the request the block reports whether the break belongs before or after the instruction executes.

Software programs the comparators through a write-only register port. The bus monitor port is a plain sampled interface with a single valid qualifier and no ready signal. A monitor may never stall the bus it observes, so the port takes no back-pressure and every valid beat is evaluated in the cycle it is presented.

Top module: `brk_cmp_top`

## Requirements
- R1: After reset every comparison register and qualifier is zero, sequential mode is off, both flags are 0 and `brk_req` is 0. A beat that matches the zeroed address and ASID therefore raises no break.
- R2: The qualifier register sits at offset 8 for channel A and offset 9 for channel B. Bits [1:0] select the access kind (bit 0 = instruction fetch, bit 1 = operand access). Bits [3:2] select the direction (bit 2 = read, bit 3 = write). A beat qualifies only if its kind bit and its direction bit are both set, so a value of 00 in either field disables the channel.
- R3: The break address is at offset 0 (A) or 1 (B), and the address mask at offset 2 (A) or 3 (B). An address matches when every bus address bit whose mask bit is 0 equals the stored bit. Bits whose mask bit is 1 are don't-care.
- R4: The ASID register is at offset 4 (A) or 5 (B). Bits [7:0] hold the ASID, and bit 8 set means the ASID is ignored. Otherwise the bus ASID must equal the stored ASID.
- R5: Channel B compares break data (offset 6) under a data mask (offset 7, a 1 bit is don't-care) when qualifier bit 5 is set and the beat is an operand access. Size 0 (byte) compares bits [7:0], size 1 (word) compares [15:0], and size 2 or 3 (longword) compares all 32 bits. Fetch beats and beats with bit 5 clear ignore the data.
- R6: In independent mode (control register at offset 10, bit 0 = 0), a qualifying beat of either channel drives `brk_req` high for exactly the one cycle after the beat's clock edge.
- R7: In sequential mode (offset 10, bit 0 = 1), channel A never requests a break, but its match sets that channel's flag and arms the block. A channel B match requests a break only if the block was armed before that beat. The armed state clears when a channel B break condition occurs or when the control register is written.
- R8: When `cpu_bl` is 1 during a matching beat, no request is raised and no flag is set.
- R9: Flags are sticky. A write to offset 10 + 1 (offset 11) clears flag A where data bit 0 is 0 and clears flag B where data bit 1 is 0. A set in the same cycle as a clear wins.
- R10: With a request, `brk_post` is 1 for an operand-access break. For a fetch break it equals qualifier bit 4 (1 = after execution) of the firing channel, with channel A taking precedence.
- R11: A beat with `mon_valid` low raises no request and sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register offset |
| cfg_wdata | input | 32 | Register write data |
| cpu_bl | input | 1 | CPU block bit; 1 suppresses breaks |
| mon_valid | input | 1 | Bus beat present this cycle |
| mon_fetch | input | 1 | 1 = instruction fetch, 0 = operand access |
| mon_write | input | 1 | 1 = write, 0 = read |
| mon_size | input | 2 | Access size: 0 byte, 1 word, 2/3 longword |
| mon_addr | input | 32 | Bus address |
| mon_asid | input | 8 | Bus address-space identifier |
| mon_data | input | 32 | Bus data, right-aligned |
| brk_req | output | 1 | One-cycle break request |
| brk_post | output | 1 | Break timing: 1 after execution, 0 before |
| brk_flag_a | output | 1 | Sticky channel A match flag |
| brk_flag_b | output | 1 | Sticky channel B match flag |

## Verification
A register write takes effect at the clock edge on which `cfg_we` is sampled. A bus beat sampled at edge n shows its `brk_req`, `brk_post` and flag results immediately after edge n, and `brk_req` falls after edge n+1. The bench drives every input on the falling edge and samples the results on the next falling edge, which is half a cycle after the edge that registers them. The request-pulse check samples one falling edge later. Sweeps over qualifier codes, address bits, ASIDs and data lanes compare each sample against a model computed arithmetically in the bench.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int NCH       = 2;
  localparam int CFG_AW    = 4;
  // register offsets (per-channel registers add the channel index)
  localparam int REG_ADDR  = 0;
  localparam int REG_AMASK = 2;
  localparam int REG_ASID  = 4;
  localparam int REG_BDATA = 6;
  localparam int REG_BMASK = 7;
  localparam int REG_QUAL  = 8;
  localparam int REG_CTRL  = 10;
  localparam int REG_FLAGS = 11;
  // qualifier bit positions
  localparam int Q_KIND    = 0;
  localparam int Q_DIR     = 2;
  localparam int Q_POST    = 4;
  localparam int Q_DATA    = 5;
  // access sizes
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;
endpackage

// File: rtl/brk_regs.sv
module brk_regs
  import brk_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int IDW = 8,
  localparam int CW = (AW > DW) ? AW : DW
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [CFG_AW-1:0]         cfg_addr,
  input  logic [CW-1:0]             cfg_wdata,
  output logic [NCH-1:0][AW-1:0]    ch_addr,
  output logic [NCH-1:0][AW-1:0]    ch_amask,
  output logic [NCH-1:0][IDW-1:0]   ch_asid,
  output logic [NCH-1:0]            ch_asid_ign,
  output logic [NCH-1:0][1:0]       ch_kind,
  output logic [NCH-1:0][1:0]       ch_dir,
  output logic [NCH-1:0]            ch_post,
  output logic [NCH-1:0]            ch_data_en,
  output logic [DW-1:0]             bk_data,
  output logic [DW-1:0]             bk_dmask,
  output logic                      seq_mode,
  output logic                      ctrl_wr,
  output logic                      flag_wr,
  output logic [NCH-1:0]            flag_keep
);
  // only the last channel carries data-compare storage
  localparam logic [NCH-1:0] DATA_CAP = NCH'(1) << (NCH - 1);

  assign ctrl_wr   = cfg_we && (cfg_addr == CFG_AW'(REG_CTRL));
  assign flag_wr   = cfg_we && (cfg_addr == CFG_AW'(REG_FLAGS));
  assign flag_keep = cfg_wdata[NCH-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_addr     <= '0;
      ch_amask    <= '0;
      ch_asid     <= '0;
      ch_asid_ign <= '0;
      ch_kind     <= '0;
      ch_dir      <= '0;
      ch_post     <= '0;
      ch_data_en  <= '0;
      bk_data     <= '0;
      bk_dmask    <= '0;
      seq_mode    <= 1'b0;
    end else if (cfg_we) begin
      for (int c = 0; c < NCH; c++) begin
        if (cfg_addr == CFG_AW'(REG_ADDR + c))  ch_addr[c]  <= cfg_wdata[AW-1:0];
        if (cfg_addr == CFG_AW'(REG_AMASK + c)) ch_amask[c] <= cfg_wdata[AW-1:0];
        if (cfg_addr == CFG_AW'(REG_ASID + c)) begin
          ch_asid[c]     <= cfg_wdata[IDW-1:0];
          ch_asid_ign[c] <= cfg_wdata[IDW];
        end
        if (cfg_addr == CFG_AW'(REG_QUAL + c)) begin
          ch_kind[c]    <= cfg_wdata[Q_KIND +: 2];
          ch_dir[c]     <= cfg_wdata[Q_DIR +: 2];
          ch_post[c]    <= cfg_wdata[Q_POST];
          ch_data_en[c] <= cfg_wdata[Q_DATA] & DATA_CAP[c];
        end
      end
      if (cfg_addr == CFG_AW'(REG_BDATA)) bk_data  <= cfg_wdata[DW-1:0];
      if (cfg_addr == CFG_AW'(REG_BMASK)) bk_dmask <= cfg_wdata[DW-1:0];
      if (ctrl_wr) seq_mode <= cfg_wdata[0];
    end
  end

  AST_DATA_ONLY_B: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_data_en & ~DATA_CAP) == '0); // R5
endmodule

// File: rtl/brk_chan.sv
module brk_chan
  import brk_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int IDW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mon_valid,
  input  logic           mon_fetch,
  input  logic           mon_write,
  input  logic [1:0]     mon_size,
  input  logic [AW-1:0]  mon_addr,
  input  logic [IDW-1:0] mon_asid,
  input  logic [DW-1:0]  mon_data,
  input  logic [AW-1:0]  bk_addr,
  input  logic [AW-1:0]  bk_amask,
  input  logic [IDW-1:0] bk_asid,
  input  logic           bk_asid_ign,
  input  logic [1:0]     bk_kind,
  input  logic [1:0]     bk_dir,
  input  logic           bk_data_en,
  input  logic [DW-1:0]  bk_data,
  input  logic [DW-1:0]  bk_dmask,
  output logic           hit
);
  logic          kind_ok, dir_ok, addr_ok, asid_ok, data_ok;
  logic [DW-1:0] lane;

  always_comb begin
    lane = '0;
    case (mon_size)
      SZ_BYTE: lane[7:0]  = '1;
      SZ_WORD: lane[15:0] = '1;
      default: lane       = '1;
    endcase
  end

  assign kind_ok = mon_fetch ? bk_kind[0] : bk_kind[1];
  assign dir_ok  = mon_write ? bk_dir[1]  : bk_dir[0];
  assign addr_ok = ((mon_addr ^ bk_addr) & ~bk_amask) == '0;
  assign asid_ok = bk_asid_ign || (mon_asid == bk_asid);
  assign data_ok = !bk_data_en || mon_fetch ||
                   (((mon_data ^ bk_data) & ~bk_dmask & lane) == '0);
  assign hit     = mon_valid && kind_ok && dir_ok && addr_ok && asid_ok && data_ok;

  AST_FIELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (bk_kind == 2'b00 || bk_dir == 2'b00) |-> !hit); // R2
endmodule

// File: rtl/brk_seq.sv
module brk_seq
  import brk_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] hit,
  input  logic           mon_fetch,
  input  logic [NCH-1:0] ch_post,
  input  logic           seq_mode,
  input  logic           ctrl_wr,
  input  logic           flag_wr,
  input  logic [NCH-1:0] flag_keep,
  input  logic           cpu_bl,
  output logic           brk_req,
  output logic           brk_post,
  output logic [NCH-1:0] flags
);
  logic           armed;
  logic           fire_a, cond_b, take, req_n, post_n;
  logic [NCH-1:0] set_f;

  assign fire_a = hit[0] && !seq_mode;
  assign cond_b = hit[1] && (!seq_mode || armed);
  assign take   = !cpu_bl;
  assign set_f  = {cond_b && take, hit[0] && take};
  assign req_n  = take && (fire_a || cond_b);
  assign post_n = !mon_fetch ? 1'b1 : (fire_a ? ch_post[0] : ch_post[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_req  <= 1'b0;
      brk_post <= 1'b0;
      flags    <= '0;
      armed    <= 1'b0;
    end else begin
      brk_req  <= req_n;
      brk_post <= req_n && post_n;
      flags    <= (flag_wr ? (flags & flag_keep) : flags) | set_f;
      if (ctrl_wr)                armed <= 1'b0;
      else if (seq_mode && hit[0]) armed <= 1'b1;
      else if (seq_mode && cond_b) armed <= 1'b0;
    end
  end

  AST_BL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> !$past(cpu_bl)); // R8
  AST_SEQ_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_req && $past(seq_mode)) |-> ($past(armed) && $past(hit[1]))); // R7
  AST_FLAG_A_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags[0]) |-> $past(flag_wr)); // R9
  AST_FLAG_B_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags[1]) |-> $past(flag_wr)); // R9
  AST_OPERAND_POST: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_req && !$past(mon_fetch)) |-> brk_post); // R10
endmodule

// File: rtl/brk_cmp_top.sv
module brk_cmp_top
  import brk_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int IDW = 8,
  localparam int CW = (AW > DW) ? AW : DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CW-1:0]     cfg_wdata,
  input  logic              cpu_bl,
  input  logic              mon_valid,
  input  logic              mon_fetch,
  input  logic              mon_write,
  input  logic [1:0]        mon_size,
  input  logic [AW-1:0]     mon_addr,
  input  logic [IDW-1:0]    mon_asid,
  input  logic [DW-1:0]     mon_data,
  output logic              brk_req,
  output logic              brk_post,
  output logic              brk_flag_a,
  output logic              brk_flag_b
);
  logic [NCH-1:0][AW-1:0]  ch_addr, ch_amask;
  logic [NCH-1:0][IDW-1:0] ch_asid;
  logic [NCH-1:0]          ch_asid_ign, ch_post, ch_data_en;
  logic [NCH-1:0][1:0]     ch_kind, ch_dir;
  logic [DW-1:0]           bk_data, bk_dmask;
  logic                    seq_mode, ctrl_wr, flag_wr;
  logic [NCH-1:0]          flag_keep, hit, flags;

  brk_regs #(.AW(AW), .DW(DW), .IDW(IDW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ch_addr(ch_addr), .ch_amask(ch_amask),
    .ch_asid(ch_asid), .ch_asid_ign(ch_asid_ign), .ch_kind(ch_kind),
    .ch_dir(ch_dir), .ch_post(ch_post), .ch_data_en(ch_data_en),
    .bk_data(bk_data), .bk_dmask(bk_dmask), .seq_mode(seq_mode),
    .ctrl_wr(ctrl_wr), .flag_wr(flag_wr), .flag_keep(flag_keep)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    brk_chan #(.AW(AW), .DW(DW), .IDW(IDW)) u_chan (
      .clk(clk), .rst_n(rst_n),
      .mon_valid(mon_valid), .mon_fetch(mon_fetch), .mon_write(mon_write),
      .mon_size(mon_size), .mon_addr(mon_addr), .mon_asid(mon_asid),
      .mon_data(mon_data),
      .bk_addr(ch_addr[c]), .bk_amask(ch_amask[c]), .bk_asid(ch_asid[c]),
      .bk_asid_ign(ch_asid_ign[c]), .bk_kind(ch_kind[c]), .bk_dir(ch_dir[c]),
      .bk_data_en(ch_data_en[c]), .bk_data(bk_data), .bk_dmask(bk_dmask),
      .hit(hit[c])
    );
  end

  brk_seq u_seq (
    .clk(clk), .rst_n(rst_n), .hit(hit), .mon_fetch(mon_fetch),
    .ch_post(ch_post), .seq_mode(seq_mode), .ctrl_wr(ctrl_wr),
    .flag_wr(flag_wr), .flag_keep(flag_keep), .cpu_bl(cpu_bl),
    .brk_req(brk_req), .brk_post(brk_post), .flags(flags)
  );

  assign brk_flag_a = flags[0];
  assign brk_flag_b = flags[1];

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> $past(mon_valid)); // R11
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_req && !mon_valid) |=> !brk_req); // R6
endmodule

// File: tb/sim_brk_cmp_top.sv
module sim_brk_cmp_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        cpu_bl = 1'b0;
  logic        mon_valid = 1'b0, mon_fetch = 1'b0, mon_write = 1'b0;
  logic [1:0]  mon_size = 2'd2;
  logic [31:0] mon_addr = '0, mon_data = '0;
  logic [7:0]  mon_asid = '0;
  logic        brk_req, brk_post, brk_flag_a, brk_flag_b;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  brk_cmp_top u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cpu_bl(cpu_bl), .mon_valid(mon_valid),
    .mon_fetch(mon_fetch), .mon_write(mon_write), .mon_size(mon_size),
    .mon_addr(mon_addr), .mon_asid(mon_asid), .mon_data(mon_data),
    .brk_req(brk_req), .brk_post(brk_post), .brk_flag_a(brk_flag_a),
    .brk_flag_b(brk_flag_b)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // drive one beat; results are sampled on return (one falling edge later)
  task automatic beat(input logic v, input logic f, input logic w, input logic [31:0] a,
                      input logic [7:0] id, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    mon_valid = v; mon_fetch = f; mon_write = w; mon_addr = a;
    mon_asid = id; mon_size = sz; mon_data = d;
    @(negedge clk);
    mon_valid = 1'b0;
  endtask

  function automatic bit data_hit(input logic [1:0] sz, input logic [31:0] d);
    logic [31:0] lane;
    lane = (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    return ((d ^ 32'h1234_5678) & ~32'h0000_00F0 & lane) == 32'h0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: zeroed registers, nothing fires even on an all-zero beat
    chk("R1 req after reset", brk_req, 0);
    chk("R1 flags after reset", {brk_flag_b, brk_flag_a}, 0);
    beat(1, 1, 0, 32'h0, 8'h0, 2'd2, 32'h0);
    chk("R1 zero beat no req", brk_req, 0);
    chk("R1 zero beat no flag", {brk_flag_b, brk_flag_a}, 0);

    // R2: sweep kind x dir x fetch x write on channel A
    wr(0, 32'h100); wr(2, 32'h0); wr(4, 32'h100);
    for (int k = 0; k < 4; k++) begin
      for (int dr = 0; dr < 4; dr++) begin
        wr(8, 32'(k | (dr << 2)));
        for (int f = 0; f < 2; f++) begin
          for (int w = 0; w < 2; w++) begin
            logic e;
            e = (f != 0 ? k[0] : k[1]) & (w != 0 ? dr[1] : dr[0]);
            wr(11, 0);
            beat(1, f[0], w[0], 32'h100, 8'h33, 2'd2, 32'h0);
            chk("R2 qualifier req", brk_req, 32'(e));
            chk("R2 qualifier flag", brk_flag_a, 32'(e));
          end
        end
      end
    end

    // R3: address mask sweep over low 8 bits
    wr(0, 32'h1000_00F0); wr(2, 32'h0000_000F); wr(8, 32'hF);
    for (int i = 0; i < 256; i++) begin
      logic [31:0] a;
      a = 32'h1000_00F0 ^ 32'(i);
      beat(1, 1, 0, a, 8'h0, 2'd2, 32'h0);
      chk("R3 masked address", brk_req, 32'((((a ^ 32'h1000_00F0) & ~32'hF) == 0)));
    end
    beat(1, 1, 0, 32'h9000_00F0, 8'h0, 2'd2, 32'h0);
    chk("R3 high bit mismatch", brk_req, 0);

    // R4: ASID compare and ignore
    wr(4, 32'h5A);
    for (int i = 0; i < 4; i++) begin
      logic [7:0] id;
      id = (i == 0) ? 8'h5A : (i == 1) ? 8'h5B : (i == 2) ? 8'h00 : 8'hA5;
      beat(1, 1, 0, 32'h1000_00F0, id, 2'd2, 32'h0);
      chk("R4 asid compare", brk_req, 32'(id == 8'h5A));
    end
    wr(4, 32'h15A);
    beat(1, 1, 0, 32'h1000_00F0, 8'hA5, 2'd2, 32'h0);
    chk("R4 asid ignored", brk_req, 1);

    // R5: channel B data compare by lane
    wr(8, 32'h0);
    wr(1, 32'h2000); wr(3, 32'h0); wr(5, 32'h100);
    wr(6, 32'h1234_5678); wr(7, 32'h0000_00F0); wr(9, 32'h2E);
    for (int s = 0; s < 4; s++) begin
      for (int j = 0; j < 6; j++) begin
        logic [31:0] d;
        case (j)
          0: d = 32'h1234_5678;
          1: d = 32'h1234_5608;
          2: d = 32'h1234_5679;
          3: d = 32'hFFFF_5678;
          4: d = 32'h0000_0078;
          default: d = 32'h0000_5078;
        endcase
        beat(1, 0, j[0], 32'h2000, 8'h0, s[1:0], d);
        chk("R5 data lanes", brk_req, 32'(data_hit(s[1:0], d)));
      end
    end
    wr(9, 32'h2F);
    beat(1, 1, 0, 32'h2000, 8'h0, 2'd2, 32'h0);
    chk("R5 fetch ignores data", brk_req, 1);
    wr(9, 32'h0E);
    beat(1, 0, 0, 32'h2000, 8'h0, 2'd2, 32'hDEAD_BEEF);
    chk("R5 data disabled", brk_req, 1);

    // R6: independent channels, one-cycle pulse
    wr(0, 32'h100); wr(2, 32'h0); wr(4, 32'h100); wr(8, 32'h5);
    wr(11, 0);
    beat(1, 1, 0, 32'h100, 8'h0, 2'd2, 32'h0);
    chk("R6 A req", brk_req, 1);
    chk("R6 A flags", {brk_flag_b, brk_flag_a}, 2'b01);
    @(negedge clk);
    chk("R6 req pulse ends", brk_req, 0);
    wr(11, 0);
    beat(1, 0, 1, 32'h2000, 8'h0, 2'd1, 32'h0);
    chk("R6 B req", brk_req, 1);
    chk("R6 B flags", {brk_flag_b, brk_flag_a}, 2'b10);

    // R7: sequential chaining
    wr(10, 1); wr(11, 0);
    beat(1, 0, 0, 32'h2000, 8'h0, 2'd2, 32'h0);
    chk("R7 B before arm", brk_req, 0);
    chk("R7 B before arm flag", brk_flag_b, 0);
    beat(1, 1, 0, 32'h100, 8'h0, 2'd2, 32'h0);
    chk("R7 A arms no req", brk_req, 0);
    chk("R7 A flag set", brk_flag_a, 1);
    beat(1, 0, 0, 32'h2000, 8'h0, 2'd2, 32'h0);
    chk("R7 B after arm", brk_req, 1);
    chk("R7 B flag", brk_flag_b, 1);
    beat(1, 0, 0, 32'h2000, 8'h0, 2'd2, 32'h0);
    chk("R7 disarmed after break", brk_req, 0);
    beat(1, 1, 0, 32'h100, 8'h0, 2'd2, 32'h0);
    wr(10, 1);
    beat(1, 0, 0, 32'h2000, 8'h0, 2'd2, 32'h0);
    chk("R7 control write disarms", brk_req, 0);

    // R8: block bit
    wr(10, 0); wr(11, 0);
    cpu_bl = 1'b1;
    beat(1, 1, 0, 32'h100, 8'h0, 2'd2, 32'h0);
    chk("R8 blocked req", brk_req, 0);
    chk("R8 blocked flags", {brk_flag_b, brk_flag_a}, 0);
    cpu_bl = 1'b0;

    // R9: sticky flags and write-zero clear
    beat(1, 1, 0, 32'h100, 8'h0, 2'd2, 32'h0);
    beat(1, 0, 0, 32'h2000, 8'h0, 2'd2, 32'h0);
    chk("R9 both set", {brk_flag_b, brk_flag_a}, 2'b11);
    wr(11, 32'h2);
    chk("R9 clear A keep B", {brk_flag_b, brk_flag_a}, 2'b10);
    wr(11, 32'h0);
    chk("R9 clear both", {brk_flag_b, brk_flag_a}, 2'b00);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'd11; cfg_wdata = 32'h0;
    mon_valid = 1'b1; mon_fetch = 1'b1; mon_write = 1'b0;
    mon_addr = 32'h100; mon_asid = 8'h0; mon_size = 2'd2;
    @(negedge clk);
    cfg_we = 1'b0; mon_valid = 1'b0;
    chk("R9 set wins over clear", brk_flag_a, 1);

    // R10: break timing indication
    wr(8, 32'h15);
    beat(1, 1, 0, 32'h100, 8'h0, 2'd2, 32'h0);
    chk("R10 fetch post", brk_post, 1);
    wr(8, 32'h05);
    beat(1, 1, 0, 32'h100, 8'h0, 2'd2, 32'h0);
    chk("R10 fetch pre", brk_post, 0);
    beat(1, 0, 1, 32'h2000, 8'h0, 2'd2, 32'h0);
    chk("R10 operand post", brk_post, 1);

    // R11: invalid beat ignored
    wr(11, 0);
    beat(0, 1, 0, 32'h100, 8'h0, 2'd2, 32'h0);
    chk("R11 invalid no req", brk_req, 0);
    chk("R11 invalid no flag", {brk_flag_b, brk_flag_a}, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule